// File: doc/BRIEF.md
# Multicycle Processor Hardwired Sequencer

This block is the hardwired finite-state controller of a 32-bit multicycle load/store processor. It receives the 6-bit opcode field held in the instruction register. It steps each instruction through a fixed set of numbered states, and in each state it drives every control strobe and select that the datapath needs. The controlled datapath elements are the program counter, the memory port, the instruction register, the register file, the ALU operand multiplexers, the immediate extender and the branch-target register. The datapath, memory, register file and ALU lie outside the block.

Every instruction begins with a fetch state and a decode state. During decode the controller computes a branch target into a dedicated register and dispatches on the opcode to a path of its own. Loads take five states, stores and register-register operations four, and branches and jumps three. Conditional branches use a conditional PC-write strobe, so the datapath decides with its zero flag whether the PC is updated. The present state number is brought out so that the sequence can be observed.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, `pc_wr`, `pc_wr_cond`, `mem_wr`, `ir_wr`, `reg_wr` and `tgt_wr` are all low. A rising clock edge with `rst_n` low puts the controller in state 0.
- R2: State 0 (fetch) drives `pc_wr`=1, `ir_wr`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=00 (constant four), `alu_op`=00 (add) and `pc_src`=00 (ALU result). All other outputs are 0, and the next state is always 1.
- R3: State 1 (decode) drives `tgt_wr`=1, `ext_sign`=1, `alu_a_sel`=0, `alu_b_sel`=10 (sign-extended immediate shifted left by two) and `alu_op`=00. All other outputs are 0.
- R4: From state 1 the next state depends on the opcode: 100011 (load) and 101011 (store) go to 2, 000000 (register-register) goes to 6, 000100 (branch-if-equal) goes to 8, 000010 (jump) goes to 9 and 001011 (or-immediate) goes to 10.
- R5: A load visits states 2, 3, 4 and then 0. All three states drive `alu_a_sel`=1, `alu_b_sel`=11 (extended immediate), `alu_op`=00 and `ext_sign`=1. State 3 adds `addr_sel`=1. State 4 adds `reg_wr`=1 and `wb_sel`=1 (memory data), with `dst_sel`=0.
- R6: A store visits states 2, 5 and then 0. State 5 drives `mem_wr`=1 and `addr_sel`=1 with the same ALU settings as state 2.
- R7: A register-register operation visits states 6, 7 and then 0, with `alu_a_sel`=1, `alu_b_sel`=01 (register B) and `alu_op`=10 (function field). State 7 adds `dst_sel`=1 and `reg_wr`=1 with `wb_sel`=0. State 6 drives `dst_sel`=1 with no writes.
- R8: Branch-if-equal uses state 8: `alu_op`=01 (subtract), `alu_a_sel`=1, `alu_b_sel`=01, `pc_wr_cond`=1 and `pc_src`=01 (branch-target register). The state that follows is 0.
- R9: Or-immediate visits states 10, 11 and then 0, with `alu_op`=11 (or), `alu_a_sel`=1, `alu_b_sel`=11 and `ext_sign`=0 (zero extension). State 11 adds `reg_wr`=1 with `dst_sel`=0 and `wb_sel`=0.
- R10: Jump uses state 9: `pc_wr`=1 and `pc_src`=10 (jump target), with all other outputs 0. The state that follows is 0.
- R11: An opcode outside the six listed returns the controller from state 1 straight to state 0, with no `reg_wr` or `mem_wr` asserted.
- R12: The opcode is only examined in states 1 and 2. A change of opcode in any other state leaves the state sequence unchanged.
- R13: In every state at most one of `reg_wr`, `mem_wr` and `tgt_wr` is high, and `mem_wr` is only ever high with `addr_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the datapath zero flag |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU result |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register write |
| dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| reg_wr | output | 1 | Register file write |
| wb_sel | output | 1 | Write-back source: 0 ALU, 1 memory data |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 four, 01 register B, 10 immediate shifted by two, 11 immediate |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field, 11 or |
| ext_sign | output | 1 | Immediate extension: 1 sign, 0 zero |
| tgt_wr | output | 1 | Branch-target register write |
| pc_src | output | 2 | PC source: 00 ALU result, 01 branch target, 10 jump target |
| state_o | output | 4 | Present state number |

## Verification
The control outputs decode the state register combinationally, so they change in the same cycle as `state_o`. A new state, chosen from the opcode presented in the cycle before, appears one rising edge after that opcode is sampled. The bench therefore applies its inputs and samples its outputs on falling edges. Each falling-edge sample is compared against one step of the expected state path and against that state's expected control word, and the opcode is held until the dispatching edge has passed. Reset gating of the write strobes is combinational, so it is checked one time step after `rst_n` falls, before any edge.

// File: rtl/mc_ctrl_pkg.sv
// Package: shared state numbering, opcode codes, field encodings and the
// control word type of the multicycle sequencer.
// Assumes: the state numbers are fixed because the datapath hand-over tables
// refer to them; encodings 12..15 never occur.
package mc_ctrl_pkg;

    localparam int OP_W = 6;
    localparam int ST_W = 4;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_REXE   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BRCMP  = 4'd8,
        ST_JUMP   = 4'd9,
        ST_OREXE  = 4'd10,
        ST_ORWB   = 4'd11
    } state_e;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'b001011;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_OR   = 2'b11
    } alu_op_e;

    localparam logic [1:0] BSEL_FOUR = 2'b00;
    localparam logic [1:0] BSEL_REGB = 2'b01;
    localparam logic [1:0] BSEL_IMM4 = 2'b10;
    localparam logic [1:0] BSEL_IMM  = 2'b11;

    localparam logic [1:0] PCSRC_SEQ = 2'b00;
    localparam logic [1:0] PCSRC_TGT = 2'b01;
    localparam logic [1:0] PCSRC_JMP = 2'b10;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       mem_wr;
        logic       ir_wr;
        logic       dst_sel;
        logic       reg_wr;
        logic       wb_sel;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        alu_op_e    alu_op;
        logic       ext_sign;
        logic       tgt_wr;
        logic [1:0] pc_src;
    } ctrl_t;

endpackage

// File: rtl/mc_state_reg.sv
// Module: holds the present state of the sequencer.
// Assumes: synchronous active-low reset returns the sequencer to fetch.
module mc_state_reg
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_e nxt,
    output state_e cur
);

    // Capture the next state, or the fetch state while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_FETCH;
        else        cur <= nxt;
    end

endmodule

// File: rtl/mc_next_state.sv
// Module: next-state function of the sequencer.
// Assumes: the opcode is stable in decode and address states; in all other
// states it is ignored. Unknown opcodes and unused codes lead back to fetch.
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  state_e          cur,
    input  logic [OP_W-1:0] opcode,
    output state_e          nxt
);

    // Pick the successor: dispatch in decode and address states, fixed links elsewhere.
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_LOAD,
                    OPC_STORE: nxt = ST_ADDR;
                    OPC_RTYPE: nxt = ST_REXE;
                    OPC_BEQ:   nxt = ST_BRCMP;
                    OPC_JUMP:  nxt = ST_JUMP;
                    OPC_ORI:   nxt = ST_OREXE;
                    default:   nxt = ST_FETCH;
                endcase
            end
            ST_ADDR:   nxt = (opcode == OPC_STORE) ? ST_STWR : ST_LDRD;
            ST_LDRD:   nxt = ST_LDWB;
            ST_REXE:   nxt = ST_RWB;
            ST_OREXE:  nxt = ST_ORWB;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_decode.sv
// Module: state-to-control-word decoder (Moore outputs).
// Assumes: outputs not needed by a state are driven to 0.
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctl
);

    // Build the control word for the present state from a zeroed default.
    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.pc_wr     = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_op    = ALU_ADD;
                ctl.pc_src    = PCSRC_SEQ;
            end
            ST_DECODE: begin
                ctl.tgt_wr    = 1'b1;
                ctl.ext_sign  = 1'b1;
                ctl.alu_b_sel = BSEL_IMM4;
            end
            ST_ADDR, ST_LDRD, ST_LDWB, ST_STWR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.ext_sign  = 1'b1;
                ctl.addr_sel  = (cur == ST_LDRD) || (cur == ST_STWR);
                ctl.mem_wr    = (cur == ST_STWR);
                ctl.reg_wr    = (cur == ST_LDWB);
                ctl.wb_sel    = (cur == ST_LDWB);
            end
            ST_REXE, ST_RWB: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REGB;
                ctl.alu_op    = ALU_FUNC;
                ctl.dst_sel   = 1'b1;
                ctl.reg_wr    = (cur == ST_RWB);
            end
            ST_BRCMP: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_b_sel  = BSEL_REGB;
                ctl.alu_op     = ALU_SUB;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = PCSRC_TGT;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCSRC_JMP;
            end
            ST_OREXE, ST_ORWB: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_op    = ALU_OR;
                ctl.reg_wr    = (cur == ST_ORWB);
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
// Module: top of the hardwired multicycle sequencer. Ties state register,
// next-state logic and control decoder together and gates every write strobe
// with reset.
// Assumes: opcode comes straight from the instruction register.
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            addr_sel,
    output logic            mem_wr,
    output logic            ir_wr,
    output logic            dst_sel,
    output logic            reg_wr,
    output logic            wb_sel,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_op,
    output logic            ext_sign,
    output logic            tgt_wr,
    output logic [1:0]      pc_src,
    output logic [ST_W-1:0] state_o
);

    state_e cur;
    state_e nxt;
    ctrl_t  ctl;

    mc_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    mc_next_state u_next (
        .cur    (cur),
        .opcode (opcode),
        .nxt    (nxt)
    );

    mc_ctrl_decode u_dec (
        .cur (cur),
        .ctl (ctl)
    );

    // Drive the ports; write strobes are forced low while reset is held.
    always_comb begin
        pc_wr      = ctl.pc_wr      & rst_n;
        pc_wr_cond = ctl.pc_wr_cond & rst_n;
        mem_wr     = ctl.mem_wr     & rst_n;
        ir_wr      = ctl.ir_wr      & rst_n;
        reg_wr     = ctl.reg_wr     & rst_n;
        tgt_wr     = ctl.tgt_wr     & rst_n;
        addr_sel   = ctl.addr_sel;
        dst_sel    = ctl.dst_sel;
        wb_sel     = ctl.wb_sel;
        alu_a_sel  = ctl.alu_a_sel;
        alu_b_sel  = ctl.alu_b_sel;
        alu_op     = ctl.alu_op;
        ext_sign   = ctl.ext_sign;
        pc_src     = ctl.pc_src;
        state_o    = cur;
    end

endmodule

// File: rtl/mc_ctrl_chk.sv
// Module: property checker for the sequencer, bound to the top module.
// Assumes: it only observes the top-level ports.
module mc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] opcode,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       addr_sel,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       reg_wr,
    input logic       tgt_wr,
    input logic [1:0] alu_op,
    input logic [1:0] pc_src,
    input logic [3:0] state_o
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !(pc_wr | pc_wr_cond | mem_wr | ir_wr | reg_wr | tgt_wr)); // R1

    AST_RESET_TO_FETCH: assert property (@(posedge clk)
        !rst_n |=> state_o == 4'd0); // R1

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 4'd0 |=> state_o == 4'd1); // R2

    AST_LOAD_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd1 && opcode == 6'b100011) |=> state_o == 4'd2); // R4

    AST_RTYPE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd1 && opcode == 6'b000000) |=> state_o == 4'd6); // R4

    AST_LOAD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 4'd3 |=> state_o == 4'd4); // R5

    AST_TERMINAL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd4 || state_o == 4'd5 || state_o == 4'd7 ||
         state_o == 4'd8 || state_o == 4'd9 || state_o == 4'd11)
        |=> state_o == 4'd0); // R12

    AST_BRANCH_COND: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |-> (pc_src == 2'b01 && alu_op == 2'b01 && !pc_wr)); // R8

    AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, mem_wr, tgt_wr})); // R13

    AST_STORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> addr_sel); // R13

    AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd1 && opcode == 6'b111111) |=> (state_o == 4'd0)); // R11

endmodule

bind mc_ctrl_fsm mc_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .addr_sel   (addr_sel),
    .mem_wr     (mem_wr),
    .ir_wr      (ir_wr),
    .reg_wr     (reg_wr),
    .tgt_wr     (tgt_wr),
    .alu_op     (alu_op),
    .pc_src     (pc_src),
    .state_o    (state_o)
);

// File: tb/tb_mc_ctrl_fsm.sv
// Bench: walks a table of instruction paths, checks state and control word at
// every step, then runs directed reset and opcode-change tests.
module tb_mc_ctrl_fsm;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    // Expected control word per state:
    // {pc_wr,pc_wr_cond,addr_sel,mem_wr, ir_wr,dst_sel,reg_wr,wb_sel,
    //  alu_a_sel, alu_b_sel[2], alu_op[2], ext_sign, tgt_wr, pc_src[2]}
    localparam logic [16:0] EXP_CTL [12] = '{
        17'b1000_1000_0_00_00_0_0_00, // 0  R2
        17'b0000_0000_0_10_00_1_1_00, // 1  R3
        17'b0000_0000_1_11_00_1_0_00, // 2  R5
        17'b0010_0000_1_11_00_1_0_00, // 3  R5
        17'b0000_0011_1_11_00_1_0_00, // 4  R5
        17'b0011_0000_1_11_00_1_0_00, // 5  R6
        17'b0000_0100_1_01_10_0_0_00, // 6  R7
        17'b0000_0110_1_01_10_0_0_00, // 7  R7
        17'b0100_0000_1_01_01_0_0_01, // 8  R8
        17'b1000_0000_0_00_00_0_0_10, // 9  R10
        17'b0000_0000_1_11_11_0_0_00, // 10 R9
        17'b0000_0010_1_11_11_0_0_00  // 11 R9
    };

    // Program vectors: {opcode[6], path length[4], path of up to six states}
    localparam int NPROG = 8;
    localparam logic [33:0] PROGS [NPROG] = '{
        {6'b100011, 4'd5, 24'h012340}, // load   R4 R5
        {6'b101011, 4'd4, 24'h012500}, // store  R4 R6
        {6'b000000, 4'd4, 24'h016700}, // rtype  R4 R7
        {6'b000100, 4'd3, 24'h018000}, // beq    R4 R8
        {6'b001011, 4'd4, 24'h01AB00}, // ori    R4 R9
        {6'b000010, 4'd3, 24'h019000}, // jump   R4 R10
        {6'b111111, 4'd2, 24'h010000}, // unknown R11
        {6'b100000, 4'd2, 24'h010000}  // unknown R11
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] opcode;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, dst_sel;
    logic       reg_wr, wb_sel, alu_a_sel, ext_sign, tgt_wr;
    logic [1:0] alu_b_sel, alu_op, pc_src;
    logic [3:0] state_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    mc_ctrl_fsm dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .pc_wr      (pc_wr),
        .pc_wr_cond (pc_wr_cond),
        .addr_sel   (addr_sel),
        .mem_wr     (mem_wr),
        .ir_wr      (ir_wr),
        .dst_sel    (dst_sel),
        .reg_wr     (reg_wr),
        .wb_sel     (wb_sel),
        .alu_a_sel  (alu_a_sel),
        .alu_b_sel  (alu_b_sel),
        .alu_op     (alu_op),
        .ext_sign   (ext_sign),
        .tgt_wr     (tgt_wr),
        .pc_src     (pc_src),
        .state_o    (state_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [16:0] got_ctl();
        return {pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, dst_sel, reg_wr, wb_sel,
                alu_a_sel, alu_b_sel, alu_op, ext_sign, tgt_wr, pc_src};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare the present state and its control word with the expected step.
    task automatic chk_step(input logic [3:0] exp_st, input string req);
        chk(state_o == exp_st, req, "state", 32'(state_o), 32'(exp_st));
        chk(got_ctl() == EXP_CTL[exp_st], req, "control word",
            32'(got_ctl()), 32'(EXP_CTL[exp_st]));
    endtask

    initial begin
        rst_n  = 1'b0;
        opcode = 6'b000000;
        repeat (3) @(negedge clk);

        // R1: reset state and quiet write strobes
        chk(state_o == 4'd0, "R1", "reset state", 32'(state_o), 32'd0);
        chk({pc_wr, pc_wr_cond, mem_wr, ir_wr, reg_wr, tgt_wr} == 6'b0, "R1",
            "writes in reset", 32'({pc_wr, pc_wr_cond, mem_wr, ir_wr, reg_wr, tgt_wr}), 32'd0);
        rst_n = 1'b1;
        #1;

        // Table walk: each program starts in state 0 at a falling edge.
        for (int p = 0; p < NPROG; p++) begin
            opcode = PROGS[p][33:28];
            for (int k = 0; k < int'(PROGS[p][27:24]); k++) begin
                chk_step(PROGS[p][23 - 4*k -: 4],
                         (p < 6) ? "R4 path" : "R11 unknown opcode");
                @(negedge clk);
            end
        end

        // R11: back in fetch after an unknown opcode, no register or memory write seen
        chk_step(4'd0, "R11");

        // R1: reset in the middle of a load write-back step
        opcode = 6'b100011;
        repeat (4) @(negedge clk);
        chk(state_o == 4'd4 && reg_wr, "R5", "load write-back reached",
            32'({state_o, reg_wr}), 32'h9);
        rst_n = 1'b0;
        #1;
        chk(!reg_wr, "R1", "reg_wr gated by reset", 32'(reg_wr), 32'd0);
        @(negedge clk);
        chk(state_o == 4'd0, "R1", "state after reset edge", 32'(state_o), 32'd0);
        chk(!pc_wr && !ir_wr, "R1", "fetch writes held off",
            32'({pc_wr, ir_wr}), 32'd0);
        rst_n = 1'b1;
        #1;
        chk_step(4'd0, "R2");

        // R12: opcode changed after the address step does not alter the load path
        @(negedge clk);
        chk_step(4'd1, "R12");
        @(negedge clk);
        chk_step(4'd2, "R12");
        @(negedge clk);
        chk_step(4'd3, "R12");
        opcode = 6'b001011;
        @(negedge clk);
        chk_step(4'd4, "R12");
        opcode = 6'b000000;
        @(negedge clk);
        chk_step(4'd0, "R12");

        // R12: opcode changed during fetch is only seen at decode
        opcode = 6'b000010;
        @(negedge clk);
        chk_step(4'd1, "R12");
        opcode = 6'b000100;
        @(negedge clk);
        chk_step(4'd8, "R12 R8");
        @(negedge clk);
        chk_step(4'd0, "R8");

        // R13: store write strobe alone and with memory address selected
        opcode = 6'b101011;
        repeat (3) @(negedge clk);
        chk(mem_wr && addr_sel && !reg_wr && !tgt_wr, "R13", "store strobes",
            32'({mem_wr, addr_sel, reg_wr, tgt_wr}), 32'hC);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule